// File: doc/BRIEF.md
# Multispeed Data-Strobe Transmit Serializer

This block takes packet data from the link side as parallel groups and turns it into a serial data-strobe pair for a cable transmitter. One group is captured per system-clock period. The number of lines that carry valid data depends on the packet speed: two lines at the base rate, four at double rate and eight at quadruple rate. Each captured group is shifted out least significant line first. Every group is spread evenly over one system-clock period.

The block runs entirely on the fast bit clock `clk_i`, which is eight times the system clock. A one-cycle pulse `sys_tick_i` marks each system-clock edge. At that edge the group, the speed code and the valid flag are sampled. An internal phase counter, restarted by every capture, derives the per-speed bit enable.

The serial stream leaves as a data line plus a strobe line. Exactly one of the two changes for each bit. When no bits are pending, both lines hold their values. While the port is receiving, the transmit enable is forced low, pending bits are dropped and no new group is captured.

Top module: `ds_tx_serializer`

## Requirements
- R1: While `rst_ni` is low, and after its release until a group is captured, `data_o`, `strobe_o` and `tx_en_o` are 0.
- R2: `speed_i` selects the group width. 0 is the base rate (lines 1:0). 1 is double rate (lines 3:0). 2 is quadruple rate (lines 7:0). 3 is handled like 0. Lines outside the selected width have no effect on the outputs.
- R3: A group is captured at a clock edge where `sys_tick_i`=1, `tx_valid_i`=1 and `rx_active_i`=0. No other edge captures a group.
- R4: Within a group, line 0 is sent first, then line 1, and so on in ascending order.
- R5: Bit k of a group appears at edge 1+k*S after the capture edge, where S is 4, 2 or 1 for the base, double or quadruple rate. The last quadruple-rate bit therefore lands on the next tick edge.
- R6: At each emitted bit, `data_o` takes the bit value. `strobe_o` inverts when the bit equals the previous `data_o` and holds otherwise, so exactly one of the two lines changes per bit.
- R7: When no bits of a captured group remain, `data_o` and `strobe_o` hold their last values, including across ticks with `tx_valid_i`=0.
- R8: `tx_en_o` goes to 1 at a capture edge. It goes to 0 at any tick edge that does not capture a group.
- R9: While `rx_active_i` is 1, `tx_en_o` is 0 in the same cycle. At an edge where `rx_active_i` is 1, no bit is emitted, the remaining bits of the current group are discarded and `data_o`/`strobe_o` do not change.
- R10: Groups captured on consecutive ticks form one gap-free stream, including when the speed changes between groups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast bit clock, 8x the system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sys_tick_i | input | 1 | One-cycle pulse marking each system-clock edge |
| tx_valid_i | input | 1 | Group on `data_i` is to be sent |
| speed_i | input | 2 | Speed code (0 base, 1 double, 2 quadruple, 3 as 0) |
| data_i | input | 8 | Parallel group, line 0 sent first |
| rx_active_i | input | 1 | Port is receiving; blocks transmission |
| data_o | output | 1 | Serial data line |
| strobe_o | output | 1 | Serial strobe line |
| tx_en_o | output | 1 | Port transmitter enable |

## Verification
All 256 group values are sent back to back at each of the four speed codes. The sweep separates lines that are used from lines that are ignored at each width. It also tells bit order and bit spacing apart per speed, and the long runs of equal bits in values such as 00 and FF check the strobe rule. A mixed sequence then interleaves idle ticks, receive-active ticks and speed changes. Directed pairs check that an idle tick right after a quadruple-rate group still delivers its last bit, while a receive-active tick in the same place drops it. The decoded line levels and the enable are compared in every fast-clock cycle against a model built only from the stated bit schedule.

// File: rtl/ds_tx_pkg.sv
package ds_tx_pkg;
  localparam logic [1:0] SPD_BASE = 2'd0;
  localparam logic [1:0] SPD_DBL  = 2'd1;
  localparam logic [1:0] SPD_QUAD = 2'd2;

  // log2 of fast-clock cycles per bit
  function automatic logic [1:0] stride_log2(input logic [1:0] spd);
    case (spd)
      SPD_QUAD: return 2'd0;
      SPD_DBL:  return 2'd1;
      default:  return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/ds_tx_rate_gen.sv
module ds_tx_rate_gen #(
  parameter int SLOT = 8,
  parameter int SH_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            restart_i,
  input  logic [SH_W-1:0] stride_log2_i,
  output logic            bit_en_o
);
  localparam int PH_W = $clog2(SLOT);

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ph_q <= '0;
    else if (restart_i) ph_q <= '0;
    else                ph_q <= ph_q + 1'b1;
  end

  assign mask     = PH_W'((1 << stride_log2_i) - 1);
  assign bit_en_o = (ph_q & mask) == '0;
endmodule

// File: rtl/ds_tx_shifter.sv
module ds_tx_shifter #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CNT_W-1:0]  nbits_i,
  input  logic              bit_en_i,
  input  logic              abort_i,
  output logic              bit_o,
  output logic              emit_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  assign emit_o = (cnt_q != '0) && bit_en_i && !abort_i;
  assign bit_o  = sh_q[0];
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (load_i) sh_q <= data_i;
    else if (emit_o) sh_q <= sh_q >> 1;
  end

  // load wins over a final bit leaving on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= nbits_i;
    else if (abort_i) cnt_q <= '0;
    else if (emit_o)  cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/ds_tx_encoder.sv
module ds_tx_encoder (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic emit_i,
  input  logic bit_i,
  output logic data_o,
  output logic strobe_o
);
  logic data_q, strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q   <= 1'b0;
      strobe_q <= 1'b0;
    end else if (emit_i) begin
      data_q   <= bit_i;
      strobe_q <= strobe_q ^ (bit_i == data_q);
    end
  end

  assign data_o   = data_q;
  assign strobe_o = strobe_q;
endmodule

// File: rtl/ds_tx_serializer.sv
module ds_tx_serializer
  import ds_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sys_tick_i,
  input  logic              tx_valid_i,
  input  logic [1:0]        speed_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rx_active_i,
  output logic              data_o,
  output logic              strobe_o,
  output logic              tx_en_o
);
  localparam int SLOT  = DATA_W;
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam int SH_W  = 2;

  logic             load;
  logic [SH_W-1:0]  sh_in, sh_q;
  logic [CNT_W-1:0] nbits;
  logic [CNT_W-1:0] cnt_w;
  logic             bit_en, emit, ser_bit;
  logic             busy_q;

  assign load  = sys_tick_i && tx_valid_i && !rx_active_i;
  assign sh_in = stride_log2(speed_i);
  assign nbits = CNT_W'(DATA_W >> sh_in);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (load)   sh_q <= sh_in;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          busy_q <= 1'b0;
    else if (rx_active_i) busy_q <= 1'b0;
    else if (sys_tick_i)  busy_q <= tx_valid_i;
  end

  assign tx_en_o = busy_q && !rx_active_i;

  ds_tx_rate_gen #(.SLOT(SLOT), .SH_W(SH_W)) u_rate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .restart_i    (load),
    .stride_log2_i(sh_q),
    .bit_en_o     (bit_en)
  );

  ds_tx_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .data_i  (data_i),
    .nbits_i (nbits),
    .bit_en_i(bit_en),
    .abort_i (rx_active_i),
    .bit_o   (ser_bit),
    .emit_o  (emit),
    .cnt_o   (cnt_w)
  );

  ds_tx_encoder u_enc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .emit_i  (emit),
    .bit_i   (ser_bit),
    .data_o  (data_o),
    .strobe_o(strobe_o)
  );
endmodule

// File: rtl/ds_tx_serializer_chk.sv
module ds_tx_serializer_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DATA_W + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sys_tick_i,
  input logic             tx_valid_i,
  input logic [1:0]       speed_i,
  input logic             rx_active_i,
  input logic             data_o,
  input logic             strobe_o,
  input logic             tx_en_o,
  input logic             busy_i,
  input logic [CNT_W-1:0] cnt_i
);
  logic past_valid;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_valid <= 1'b0;
    else         past_valid <= 1'b1;
  end

  p_single_toggle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_valid |-> $countones({data_o ^ $past(data_o), strobe_o ^ $past(strobe_o)}) <= 1);

  p_rx_gates_en_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_active_i |-> !tx_en_o);

  p_rx_holds_lines_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_active_i |=> ($stable(data_o) && $stable(strobe_o)));

  p_idle_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0) |=> ($stable(data_o) && $stable(strobe_o)));

  p_load_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_tick_i && tx_valid_i && !rx_active_i) |=> busy_i);

  p_noload_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_tick_i && !tx_valid_i) |=> !busy_i);

  p_quad_count_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_tick_i && tx_valid_i && !rx_active_i && speed_i == 2'd2) |=> (cnt_i == CNT_W'(DATA_W)));

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CNT_W'(DATA_W));
endmodule

bind ds_tx_serializer ds_tx_serializer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sys_tick_i (sys_tick_i),
  .tx_valid_i (tx_valid_i),
  .speed_i    (speed_i),
  .rx_active_i(rx_active_i),
  .data_o     (data_o),
  .strobe_o   (strobe_o),
  .tx_en_o    (tx_en_o),
  .busy_i     (busy_q),
  .cnt_i      (cnt_w)
);

// File: tb/ds_tx_serializer_tb.sv
module ds_tx_serializer_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sys_tick_i = 1'b0;
  logic       tx_valid_i = 1'b0;
  logic [1:0] speed_i = 2'd0;
  logic [7:0] data_i = 8'h00;
  logic       rx_active_i = 1'b0;
  logic       data_o, strobe_o, tx_en_o;

  int n_cmp = 0;
  int n_bad = 0;

  logic       exp_d = 1'b0, exp_s = 1'b0;
  logic       prev_loaded = 1'b0;
  logic [1:0] prev_spd = 2'd0;
  logic [7:0] prev_dat = 8'h00;

  always #10 clk_i = ~clk_i;

  ds_tx_serializer #(.DATA_W(8)) u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sys_tick_i (sys_tick_i),
    .tx_valid_i (tx_valid_i),
    .speed_i    (speed_i),
    .data_i     (data_i),
    .rx_active_i(rx_active_i),
    .data_o     (data_o),
    .strobe_o   (strobe_o),
    .tx_en_o    (tx_en_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int bits_of(input logic [1:0] sp);
    return (sp == 2'd1) ? 4 : (sp == 2'd2) ? 8 : 2;  // R2: code 3 acts as base rate
  endfunction

  // R6 rule applied to the bench's own line model
  task automatic push_bit(input logic b);
    if (b == exp_d) exp_s = ~exp_s;
    exp_d = b;
  endtask

  // one system-clock period: tick edge plus seven further fast edges
  task automatic slot(input logic v, input logic [1:0] sp, input logic [7:0] d, input logic rx);
    logic loaded;
    int   nb, st;
    loaded = v && !rx;  // R3
    nb = bits_of(sp);
    st = 8 / nb;        // R5 spacing
    sys_tick_i = 1'b1; tx_valid_i = v; speed_i = sp; data_i = d; rx_active_i = rx;
    for (int c = 0; c < 8; c++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      if (c == 0) sys_tick_i = 1'b0;
      if (c == 0) begin
        // R5/R10: last quadruple-rate bit of the previous group; R9 drops it
        if (prev_loaded && prev_spd == 2'd2 && !rx) push_bit(prev_dat[7]);
      end else if (loaded && ((c - 1) % st) == 0 && ((c - 1) / st) < nb) begin
        push_bit(d[(c - 1) / st]);  // R4 ascending order
      end
      check("R6 data_o", {7'd0, data_o}, {7'd0, exp_d});
      check("R6 strobe_o", {7'd0, strobe_o}, {7'd0, exp_s});
      check("R8 tx_en_o", {7'd0, tx_en_o}, {7'd0, loaded});
    end
    prev_loaded = loaded;
    prev_spd    = sp;
    prev_dat    = d;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 data_o in reset", {7'd0, data_o}, 8'h00);
    check("R1 strobe_o in reset", {7'd0, strobe_o}, 8'h00);
    check("R1 tx_en_o in reset", {7'd0, tx_en_o}, 8'h00);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    check("R1 outputs after release", {5'd0, data_o, strobe_o, tx_en_o}, 8'h00);

    // R7: idle ticks keep everything at rest
    slot(1'b0, 2'd2, 8'hff, 1'b0);
    slot(1'b0, 2'd0, 8'h55, 1'b0);

    // R2 R4 R5 R6 R10: exhaustive groups at every speed code, back to back
    for (int sp = 0; sp < 4; sp++)
      for (int v = 0; v < 256; v++)
        slot(1'b1, sp[1:0], v[7:0], 1'b0);

    // R5 R7: idle tick after quadruple rate still delivers bit 7
    slot(1'b1, 2'd2, 8'h7f, 1'b0);
    slot(1'b0, 2'd0, 8'h00, 1'b0);
    slot(1'b0, 2'd0, 8'h00, 1'b0);
    // R9: receive tick after quadruple rate drops bit 7 and blocks capture
    slot(1'b1, 2'd2, 8'h7f, 1'b0);
    slot(1'b1, 2'd0, 8'h03, 1'b1);
    slot(1'b0, 2'd0, 8'h00, 1'b0);

    // R3 R8 R9 R10: mixed idle, receive and speed changes
    for (int i = 0; i < 96; i++)
      slot((i % 5) != 0, 2'(i % 4), 8'(i * 37 + 11), (i % 7) == 3);
    slot(1'b0, 2'd0, 8'h00, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule